// File: doc/BRIEF.md
# Bit-Serial Hierarchical Routing Switch

This block is one routing node in a tree-shaped, bit-serial interconnect. It sits above four child clusters and below one parent node. Each wire in the fabric is time-multiplexed: over a frame of eight ticks it carries eight different nets, one per tick. Every tick, each output of the switch reads its own select field and picks one input wire.

In the upward direction, eight serial outputs each pick one of the sixteen child output wires. In the downward direction, each child gets six serial wires. Each of these picks one of 24 candidates: the sixteen child wires or the eight parent wires. Select codes past the candidate range drive a constant zero.

Eight per-tick configuration words hold the selects. A shared tick counter chooses the word in use. The whole image is shifted in one bit per clock through an enable and data pair before operation. The muxes are combinational within a tick, and the switch holds no state other than its configuration and the tick counter.

Top module: `serial_route_switch`

## Requirements
- R1: After reset the tick counter is 0 and every configuration bit is 0. With this configuration, every upward and downward output equals child wire 0 (`child_up_i[0]`).
- R2: While `cfg_en` is 1, each clock shifts the whole 1216-bit image up by one bit, with `cfg_din` entering bit 0, and the tick counter is held at 0. While `cfg_en` is 0, the image does not change.
- R3: While `cfg_en` is 0, the tick counter advances by one each clock and wraps from 7 to 0. Its value is visible on `tick_o`.
- R4: In tick t, the word in use is image bits [t*152 +: 152]. Upward output u equals `child_up_i[s]`, where s is word bits [u*4 +: 4].
- R5: Downward wire i, for child c and wire d with i = c*6+d, uses select code s from word bits [32 + i*5 +: 5]. A code s in 0..15 drives `child_up_i[s]`, where child k's wire w has index k*4+w.
- R6: A downward select code s in 16..23 drives `parent_dn_i[s-16]`.
- R7: A downward select code s in 24..31 drives 0, whatever the inputs are.
- R8: After a load of 1216 bits, the first bit shifted in sits at image bit 1215 (the top of the tick-7 word), and the last bit shifted in sits at image bit 0.
- R9: Each tick uses only its own word. The same output can take different sources on consecutive ticks within one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Serial configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| child_up_i | input | 16 | Serial output wires from the four children (child k, wire w at bit k*4+w) |
| parent_dn_i | input | 8 | Serial wires arriving from the parent |
| up_o | output | 8 | Serial wires toward the parent |
| child_dn_o | output | 24 | Serial wires toward the children (child c, wire d at bit c*6+d) |
| tick_o | output | 3 | Current tick within the frame |

## Verification
The properties assume that `cfg_en` is a clean level, sampled only at rising edges. They also assume that the configuration is not expected to change while `cfg_en` is low.

The stimulus changes every input only on falling edges. Loading and routing phases never overlap: `cfg_en` stays high for exactly one full image length and then drops for the routing phase.

The routing patterns cover all three downward code ranges. They include images that use only the high codes, while every input is driven to 1, to expose any leak past the zero range.

// File: rtl/serial_route_switch.sv
module serial_route_switch #(
  parameter int NCHILD   = 4,
  parameter int CHILD_W  = 4,
  parameter int PARENT_W = 8,
  parameter int UP_W     = 8,
  parameter int DN_W     = 6,
  parameter int TICKS    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_en,
  input  logic                      cfg_din,
  input  logic [NCHILD*CHILD_W-1:0] child_up_i,
  input  logic [PARENT_W-1:0]       parent_dn_i,
  output logic [UP_W-1:0]           up_o,
  output logic [NCHILD*DN_W-1:0]    child_dn_o,
  output logic [$clog2(TICKS)-1:0]  tick_o
);
  localparam int NCW   = NCHILD * CHILD_W;
  localparam int USEL  = $clog2(NCW);
  localparam int NCAND = NCW + PARENT_W;
  localparam int DSEL  = $clog2(NCAND);
  localparam int NDN   = NCHILD * DN_W;
  localparam int UBITS = UP_W * USEL;
  localparam int WORD  = UBITS + NDN * DSEL;
  localparam int TOTAL = WORD * TICKS;
  localparam int TW    = $clog2(TICKS);

  logic [TOTAL-1:0] cfg_q;
  logic [TW-1:0]    tick_q;
  logic [WORD-1:0]  word;
  logic [(1<<DSEL)-1:0] cand;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cfg_q <= '0;
    else if (cfg_en)  cfg_q <= {cfg_q[TOTAL-2:0], cfg_din};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        tick_q <= '0;
    else if (cfg_en)                   tick_q <= '0;
    else if (tick_q == TW'(TICKS-1))   tick_q <= '0;
    else                               tick_q <= tick_q + 1'b1;

  assign tick_o = tick_q;
  assign word   = cfg_q[tick_q*WORD +: WORD];
  assign cand   = {{((1<<DSEL)-NCAND){1'b0}}, parent_dn_i, child_up_i};

  for (genvar u = 0; u < UP_W; u++) begin : g_up
    logic [USEL-1:0] sel;
    assign sel     = word[u*USEL +: USEL];
    assign up_o[u] = child_up_i[sel];
  end

  for (genvar i = 0; i < NDN; i++) begin : g_dn
    logic [DSEL-1:0] sel;
    assign sel           = word[UBITS + i*DSEL +: DSEL];
    assign child_dn_o[i] = cand[sel];
  end

  AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_q[0] == $past(cfg_din)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_q)); // R2
  AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> tick_o == '0); // R2
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && tick_o != TW'(TICKS-1)) |=> tick_o == TW'($past(tick_o) + 1'b1)); // R3
  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && tick_o == TW'(TICKS-1)) |=> tick_o == '0); // R3
  AST_HIGH_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word[UBITS +: DSEL] >= DSEL'(NCAND)) |-> !child_dn_o[0]); // R7
endmodule

// File: tb/serial_route_switch_tb_top.sv
module serial_route_switch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORD  = 152;
  localparam int TOTAL = 1216;

  typedef struct {
    logic [7:0]  up;
    logic [23:0] dn;
    logic [2:0]  tk;
    string       tag_up;
    string       tag_dn;
  } exp_t;

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_din = 0;
  logic [15:0] child_up_i = '0;
  logic [7:0]  parent_dn_i = '0;
  logic [7:0]  up_o;
  logic [23:0] child_dn_o;
  logic [2:0]  tick_o;

  serial_route_switch dut_i (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .child_up_i(child_up_i), .parent_dn_i(parent_dn_i), .up_o(up_o),
    .child_dn_o(child_dn_o), .tick_o(tick_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];
  logic [TOTAL-1:0] mcfg = '0;
  int mtick = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic void set_up(int t, int u, int v);
    mcfg[t*WORD + u*4 +: 4] = 4'(v);
  endfunction
  function automatic void set_dn(int t, int i, int v);
    mcfg[t*WORD + 32 + i*5 +: 5] = 5'(v);
  endfunction

  // driver: predicts outputs from the requirement-level model (R4..R9)
  task automatic apply(input logic [15:0] ch, input logic [7:0] pa, input string tu, input string td);
    exp_t e;
    logic [WORD-1:0] w;
    w = mcfg[mtick*WORD +: WORD];
    for (int u = 0; u < 8; u++) e.up[u] = ch[w[u*4 +: 4]];
    for (int i = 0; i < 24; i++) begin
      int s;
      s = int'(w[32 + i*5 +: 5]);
      e.dn[i] = (s < 16) ? ch[s] : (s < 24) ? pa[s-16] : 1'b0;
    end
    e.tk = 3'(mtick);
    e.tag_up = tu; e.tag_dn = td;
    child_up_i = ch; parent_dn_i = pa;
    q.push_back(e);
    @(negedge clk);
    mtick = (mtick + 1) % 8;
  endtask

  // R2 R8: shift image in, top bit first
  task automatic load();
    cfg_en = 1;
    for (int i = TOTAL-1; i >= 0; i--) begin
      cfg_din = mcfg[i];
      @(negedge clk);
      if (i == TOTAL/2) check(tick_o == 3'd0, "R2 tick held during load", 32'(tick_o), 0);
    end
    cfg_en = 0;
    mtick = 0;
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(up_o == e.up, e.tag_up, 32'(up_o), 32'(e.up));
      check(child_dn_o == e.dn, e.tag_dn, 32'(child_dn_o), 32'(e.dn));
      check(tick_o == e.tk, "R3 tick", 32'(tick_o), 32'(e.tk));
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    mtick = 0;
    // R1: cleared image, all outputs follow child wire 0; R3 tick counts and wraps
    for (int k = 0; k < 10; k++)
      apply(16'(k[0] ? 16'h0001 : 16'hFFFE), 8'hFF, "R1 up after reset", "R1 dn after reset");

    // image A: mixed codes over all ranges, differing per tick (R4 R5 R6 R7 R8 R9)
    for (int t = 0; t < 8; t++) begin
      for (int u = 0; u < 8; u++) set_up(t, u, (t*3 + u*5 + 1) % 16);
      for (int i = 0; i < 24; i++) set_dn(t, i, (t*7 + i*5 + 3) % 32);
    end
    load();
    for (int k = 0; k < 24; k++)
      apply(16'($urandom), 8'($urandom), "R4 R8 R9 up mix", "R5 R6 R7 R9 dn mix");
    apply(16'hA5C3, 8'h3C, "R4 up", "R5 R6 R7 dn");

    // image B: downward codes only in the zero range, all inputs high (R7)
    for (int t = 0; t < 8; t++) begin
      for (int u = 0; u < 8; u++) set_up(t, u, 15 - u);
      for (int i = 0; i < 24; i++) set_dn(t, i, 24 + (i + t) % 8);
    end
    load();
    for (int k = 0; k < 8; k++) apply(16'hFFFF, 8'hFF, "R4 up reversed", "R7 dn zero codes");

    // image C: parent-only downward codes, walking one on the parent (R6)
    for (int t = 0; t < 8; t++) begin
      for (int u = 0; u < 8; u++) set_up(t, u, t*2);
      for (int i = 0; i < 24; i++) set_dn(t, i, 16 + (i + t) % 8);
    end
    load();
    for (int k = 0; k < 16; k++) apply(16'(1 << k), 8'(1 << (k % 8)), "R4 up per tick", "R6 dn parent codes");

    // image D: child-only downward codes, walking one on children (R5)
    for (int t = 0; t < 8; t++) begin
      for (int u = 0; u < 8; u++) set_up(t, u, (u + t) % 16);
      for (int i = 0; i < 24; i++) set_dn(t, i, (i + 2*t) % 16);
    end
    load();
    for (int k = 0; k < 16; k++) apply(16'(1 << k), 8'hFF, "R4 up rotate", "R5 dn child codes");

    @(negedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule